// File: doc/BRIEF.md
# Dual-Width Accumulator ALU with Decimal Add

A purely combinational arithmetic and logic unit for an accumulator machine. It takes the accumulator value, a memory operand, the current carry, a decimal-mode flag and a width flag. It returns the new accumulator value and fresh carry, zero, negative and overflow flags. The decode stage in front of it picks one of four operations: add with carry, bitwise AND, shift left by one, or compare. The decode stage then decides which outputs to latch.

The width flag sets the operand size at run time. When it is 0 the full 16 bits take part. When it is 1 only the low byte is used, and the upper byte of the accumulator passes through untouched. The decimal flag turns the add into a packed-BCD add with a correction on each digit. All flags follow the active width.

Top module: `acc_alu`

## Requirements
- R1: With `op_sel` = 2'b00 and `dec_mode` = 0, the active bits of `result` are acc + mem + carry_in modulo 2^width. `c_out` is the carry out of the top active bit.
- R2: With `op_sel` = 2'b00 and `dec_mode` = 1, the operands are packed BCD (4 digits when 16-bit, 2 when 8-bit). Any digit sum above 9 is corrected by +6 and carries into the next digit. `c_out` is the carry out of the top active digit.
- R3: `v_out` is 1 exactly when a binary add overflows as a signed number, meaning both operands share a top active bit and the result's top bit differs from it. `v_out` is 0 for a decimal add and for every other operation.
- R4: With `op_sel` = 2'b01, the active bits of `result` are acc AND mem, and `c_out` equals `carry_in`.
- R5: With `op_sel` = 2'b10, the active bits are acc shifted left by one with bit 0 forced to 0. `c_out` is the pre-shift bit 15 when `narrow` = 0, and bit 7 when `narrow` = 1.
- R6: With `op_sel` = 2'b11, `result` equals `acc_in` in all 16 bits. `c_out` is 1 when the active acc is at least the active mem (unsigned). `z_out` and `n_out` come from the active-width difference acc - mem.
- R7: When `narrow` = 1, `result[15:8]` equals `acc_in[15:8]` for every operation, and the upper bytes of the operands have no effect on any output.
- R8: `n_out` is the top active bit of the operation's value (the difference for compare, the result otherwise). `z_out` is 1 exactly when all active bits of that value are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation: 00 add, 01 AND, 10 shift left, 11 compare |
| acc_in | input | 16 | Accumulator operand |
| mem_in | input | 16 | Memory operand |
| carry_in | input | 1 | Incoming carry flag |
| dec_mode | input | 1 | 1 selects packed-BCD add |
| narrow | input | 1 | 1 selects 8-bit width, 0 selects 16-bit |
| result | output | 16 | New accumulator value |
| c_out | output | 1 | New carry flag |
| z_out | output | 1 | New zero flag |
| n_out | output | 1 | New negative flag |
| v_out | output | 1 | New overflow flag |

## Verification
The block holds no state, so any fault in it shows up on the outputs within the same cycle the inputs are applied. The key signals are the internal carry chains. A decimal digit carry that is lost or misplaced shows up as a wrong BCD digit, or as a wrong `c_out` at a 99/9999 rollover. A carry or borrow taken from the wrong half shows up only in 8-bit mode: there `c_out`, `z_out` and `n_out` must come from bit 7, and the upper byte must come back unchanged. The vectors are picked so that the flags computed over 8 bits and over 16 bits disagree.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 16
) (
  input  logic [1:0]   op_sel,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] mem_in,
  input  logic         carry_in,
  input  logic         dec_mode,
  input  logic         narrow,
  output logic [W-1:0] result,
  output logic         c_out,
  output logic         z_out,
  output logic         n_out,
  output logic         v_out
);
  localparam int H  = W / 2;
  localparam int ND = W / 4;
  localparam logic [1:0] OP_ADD = 2'b00, OP_AND = 2'b01, OP_SHL = 2'b10, OP_CMP = 2'b11;

  logic [H:0] lsum, hsum, ldif, hdif;
  assign lsum = {1'b0, acc_in[H-1:0]} + {1'b0, mem_in[H-1:0]} + {{H{1'b0}}, carry_in};
  assign hsum = {1'b0, acc_in[W-1:H]} + {1'b0, mem_in[W-1:H]} + {{H{1'b0}}, lsum[H]};
  assign ldif = {1'b0, acc_in[H-1:0]} - {1'b0, mem_in[H-1:0]};
  assign hdif = {1'b0, acc_in[W-1:H]} - {1'b0, mem_in[W-1:H]} - {{H{1'b0}}, ldif[H]};

  logic [W-1:0] bin_r, dif_r, dec_r;
  assign bin_r = {hsum[H-1:0], lsum[H-1:0]};
  assign dif_r = {hdif[H-1:0], ldif[H-1:0]};

  logic [ND:0] dcy;
  assign dcy[0] = carry_in;
  for (genvar g = 0; g < ND; g++) begin : g_dig
    logic [4:0] raw;
    logic [3:0] fix;
    assign raw = {1'b0, acc_in[4*g +: 4]} + {1'b0, mem_in[4*g +: 4]} + {4'b0, dcy[g]};
    assign fix = raw[3:0] + 4'd6;
    assign dcy[g+1] = raw > 5'd9;
    assign dec_r[4*g +: 4] = dcy[g+1] ? fix : raw[3:0];
  end

  logic a_top, m_top, r_top;
  assign a_top = narrow ? acc_in[H-1] : acc_in[W-1];
  assign m_top = narrow ? mem_in[H-1] : mem_in[W-1];
  assign r_top = narrow ? bin_r[H-1]  : bin_r[W-1];

  logic [W-1:0] core, fval;
  always_comb begin
    core  = acc_in;
    c_out = carry_in;
    v_out = 1'b0;
    unique case (op_sel)
      OP_ADD: if (dec_mode) begin
        core  = dec_r;
        c_out = narrow ? dcy[ND/2] : dcy[ND];
      end else begin
        core  = bin_r;
        c_out = narrow ? lsum[H] : hsum[H];
        v_out = (a_top == m_top) && (r_top != a_top);
      end
      OP_AND: core = acc_in & mem_in;
      OP_SHL: begin
        core  = {acc_in[W-2:0], 1'b0};
        c_out = a_top;
      end
      OP_CMP: c_out = ~(narrow ? ldif[H] : hdif[H]);
      default: ;
    endcase
  end

  assign fval   = (op_sel == OP_CMP) ? dif_r : core;
  assign result = (op_sel == OP_CMP) ? acc_in :
                  narrow ? {acc_in[W-1:H], core[H-1:0]} : core;
  assign z_out  = narrow ? (fval[H-1:0] == '0) : (fval == '0);
  assign n_out  = narrow ? fval[H-1] : fval[W-1];
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int W = 16
) (
  input logic [1:0]   op_sel,
  input logic [W-1:0] acc_in,
  input logic [W-1:0] mem_in,
  input logic         carry_in,
  input logic         dec_mode,
  input logic         narrow,
  input logic [W-1:0] result,
  input logic         c_out,
  input logic         z_out,
  input logic         n_out,
  input logic         v_out
);
  localparam int H = W / 2;
  logic [W-1:0] amask;
  assign amask = narrow ? {{H{1'b0}}, {H{1'b1}}} : {W{1'b1}};

  always_comb begin
    if (narrow)
      AST_UPPER_KEPT: assert (result[W-1:H] == acc_in[W-1:H]) else $error("upper byte"); // R7
    if (op_sel == 2'b11)
      AST_CMP_ACC_SAME: assert (result == acc_in) else $error("cmp changed acc"); // R6
    if (op_sel == 2'b01)
      AST_AND_BITS: assert (((result ^ (acc_in & mem_in)) & amask) == '0 && c_out == carry_in) else $error("and"); // R4
    if (op_sel == 2'b10)
      AST_SHL_LSB: assert (result[0] == 1'b0 && c_out == (narrow ? acc_in[H-1] : acc_in[W-1])) else $error("shl"); // R5
    if (op_sel != 2'b11)
      AST_ZERO_FLAG: assert (z_out == ((result & amask) == '0)) else $error("z"); // R8
    if (op_sel != 2'b11)
      AST_NEG_FLAG: assert (n_out == (narrow ? result[H-1] : result[W-1])) else $error("n"); // R8
    if (op_sel != 2'b00 || dec_mode)
      AST_NO_OVERFLOW: assert (!v_out) else $error("v"); // R3
  end
  logic unused;
  assign unused = ^mem_in;
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .op_sel(op_sel), .acc_in(acc_in), .mem_in(mem_in), .carry_in(carry_in),
  .dec_mode(dec_mode), .narrow(narrow), .result(result), .c_out(c_out),
  .z_out(z_out), .n_out(n_out), .v_out(v_out)
);

// File: tb/test_acc_alu.sv
module test_acc_alu;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]  op_sel;
  logic [15:0] acc_in, mem_in, result;
  logic carry_in, dec_mode, narrow, c_out, z_out, n_out, v_out;
  int n_chk = 0, n_fail = 0;

  acc_alu i_acc_alu (.op_sel(op_sel), .acc_in(acc_in), .mem_in(mem_in), .carry_in(carry_in),
    .dec_mode(dec_mode), .narrow(narrow), .result(result), .c_out(c_out), .z_out(z_out),
    .n_out(n_out), .v_out(v_out));

  function automatic int bcd2int(input logic [15:0] x, input int nd);
    int v = 0;
    for (int i = nd - 1; i >= 0; i--) v = v * 10 + int'((x >> (4*i)) & 16'hF);
    return v;
  endfunction

  function automatic logic [15:0] int2bcd(input int v, input int nd);
    logic [15:0] r = '0;
    for (int i = 0; i < nd; i++) begin r[4*i +: 4] = 4'(v % 10); v = v / 10; end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic run(input string tag, input logic [1:0] op, input logic [15:0] a, input logic [15:0] m,
                     input logic c, input logic d, input logic nw);
    logic [15:0] mask, top, r, fv, er;
    logic cf, vf;
    int s, lim, nd;
    @(posedge clk);
    op_sel = op; acc_in = a; mem_in = m; carry_in = c; dec_mode = d; narrow = nw;
    mask = nw ? 16'h00FF : 16'hFFFF;
    top  = nw ? 16'h0080 : 16'h8000;
    cf = c; vf = 1'b0; r = '0; fv = '0;
    case (op)
      2'b00: if (d) begin
        nd = nw ? 2 : 4; lim = nw ? 100 : 10000;
        s = bcd2int(a & mask, nd) + bcd2int(m & mask, nd) + int'(c);
        cf = s >= lim; r = int2bcd(s % lim, nd);
      end else begin
        s = int'(a & mask) + int'(m & mask) + int'(c);
        r = 16'(s) & mask; cf = s > int'(mask);
        vf = (((a ^ r) & (m ^ r) & top) != 0);
      end
      2'b01: r = a & m & mask;
      2'b10: begin r = (a << 1) & mask; cf = (a & top) != 0; end
      default: begin r = ((a & mask) - (m & mask)) & mask; cf = (a & mask) >= (m & mask); end
    endcase
    fv = r;
    er = (op == 2'b11) ? a : ((a & ~mask) | r);
    #5;
    chk({tag, " result"}, result, er);
    chk({tag, " C"}, {15'b0, c_out}, {15'b0, cf});
    chk({tag, " Z (R8)"}, {15'b0, z_out}, {15'b0, fv == 16'h0});
    chk({tag, " N (R8)"}, {15'b0, n_out}, {15'b0, (fv & top) != 0});
    chk({tag, " V (R3)"}, {15'b0, v_out}, {15'b0, vf});
  endtask

  task automatic t_reset_state;   run("R1 zero", 2'b00, 16'h0, 16'h0, 0, 0, 0); endtask
  task automatic t_add_binary;
    run("R1 R3 16b signed ovf", 2'b00, 16'h7FFF, 16'h0001, 0, 0, 0);
    run("R1 16b wrap", 2'b00, 16'hFFFF, 16'h0001, 0, 0, 0);
    run("R1 16b cin", 2'b00, 16'h1234, 16'h1111, 1, 0, 0);
    run("R1 R3 8b ovf", 2'b00, 16'hAB7F, 16'h0001, 0, 0, 1);
    run("R1 R7 8b wrap", 2'b00, 16'hABFF, 16'h5501, 0, 0, 1);
  endtask
  task automatic t_add_decimal;
    run("R2 digit ripple", 2'b00, 16'h0999, 16'h0001, 0, 1, 0);
    run("R2 16b rollover", 2'b00, 16'h9999, 16'h0001, 0, 1, 0);
    run("R2 16b cin", 2'b00, 16'h1234, 16'h5678, 1, 1, 0);
    run("R2 R7 8b rollover", 2'b00, 16'h7745, 16'h0055, 0, 1, 1);
    run("R2 8b cin", 2'b00, 16'h0019, 16'h9928, 1, 1, 1);
  endtask
  task automatic t_and;
    run("R4 16b", 2'b01, 16'hF0F0, 16'h3C3C, 1, 0, 0);
    run("R4 R7 8b zero", 2'b01, 16'h12F0, 16'hFF0F, 0, 0, 1);
  endtask
  task automatic t_shift;
    run("R5 16b bit15", 2'b10, 16'h8001, 16'h0, 0, 0, 0);
    run("R5 8b bit7", 2'b10, 16'h5580, 16'h0, 0, 0, 1);
    run("R5 8b bit15 ignored", 2'b10, 16'hC040, 16'h0, 1, 0, 1);
  endtask
  task automatic t_compare;
    run("R6 equal", 2'b11, 16'h1234, 16'h1234, 0, 0, 0);
    run("R6 less", 2'b11, 16'h0001, 16'h0002, 1, 0, 0);
    run("R6 R7 8b ge", 2'b11, 16'h0180, 16'hFF7F, 0, 0, 1);
    run("R6 decimal flag ignored", 2'b11, 16'h0050, 16'h0060, 0, 1, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    op_sel = '0; acc_in = '0; mem_in = '0; carry_in = 0; dec_mode = 0; narrow = 0;
    t_reset_state();
    t_add_binary();
    t_add_decimal();
    t_and();
    t_shift();
    t_compare();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule